// File: doc/BRIEF.md
# Configuration Image Header Parser

This block watches the opening bytes of a configuration image as they stream past, one byte per accepted handshake, and pulls out two facts: the byte offset where the payload starts, and how many payload bytes follow. It keeps its own count of byte positions. It keeps only the few header fields it needs and never stores the image.

The header works like this. A length byte gives the size of the fixed header, and the last byte of that header holds the number of records in a lookup table. The table follows directly after the header. Each record is nine bytes long: an identifier byte, then a 32-bit little-endian offset, then padding. One identifier names the payload start and another names an array of packed size fields. The parser then reads a little-endian component count from the header, unpacks that many 22-bit sizes from the array, and scales their sum by the 16-byte frame size.

The fields must arrive in increasing offset order. The parser takes exactly one image after each reset. It ends in one of two states: done, with both results valid, or a format error.

Top module: `imghdr_parser`

## Requirements
- R1: The header length is read from byte 24. A value below 26 is a format error.
- R2: The record count is read from the byte at (header length − 1), and a count of zero is a format error. The table starts at the header length. Each record is 9 bytes: the identifier is in record byte 0, and a little-endian 32-bit offset is in record bytes 1 to 4 (byte 1 least significant).
- R3: A record with identifier 8 sets `pay_start`, and a record with identifier 5 sets the size-array position. A later record with the same identifier, seen before both have been found, replaces the earlier value. Once both have been found, the remaining records are not examined.
- R4: If all records are read and either identifier has not been seen, the result is a format error.
- R5: The component count is little-endian 16-bit at bytes 55 (low) and 56 (high). A size-array position below 57, or not greater than the index of the byte that completes the table walk, is a format error.
- R6: Component size i is a 22-bit field starting at bit 22·i from bit 0 of the size-array byte, with bits numbered least significant first within each byte and bytes in increasing order. `pay_bytes` equals 16 times the sum of the sizes. `done` rises in the cycle after the byte holding the last bit of the last field is accepted.
- R7: When the component count is zero, `done` rises after the byte at the size-array position is accepted, and `pay_bytes` is 0.
- R8: If a byte accepted with `in_last` high does not complete the parse, the result is a format error.
- R9: `done` and `fmt_err` are never high together. Each stays high until reset. While either is high, `in_ready` is low, and `pay_start` and `pay_bytes` hold their values whatever the input does.
- R10: After reset, `in_ready` is high, `done` and `fmt_err` are low, and `pay_start` and `pay_bytes` are zero.
- R11: A byte is consumed only in a cycle where `in_valid` and `in_ready` are both high. Idle cycles between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte is the last one of the stream |
| in_ready | output | 1 | Parser accepts bytes |
| done | output | 1 | Parse finished; results are valid |
| fmt_err | output | 1 | Header is malformed or the stream ended early |
| pay_start | output | 32 | Byte offset of the payload start |
| pay_bytes | output | 42 | Payload length in bytes |

## Verification
The bench builds the parser with the default 32-bit byte index and the fixed 22-bit size and 16-bit count widths. With these settings, one image of 40 all-ones size fields gives a byte count above 2^31, which exercises the upper bits of the 42-bit result. Every image is generated from a short descriptor. Each descriptor lets the bench place the lookup records, decoy records and duplicated identifiers wherever it chooses. It can also put the size array exactly at the lowest legal position or just behind the end of the table walk.

// File: rtl/imghdr_pkg.sv
package imghdr_pkg;

    // Header layout constants
    localparam int unsigned LEN_POS      = 24;
    localparam int unsigned NCOMP_POS    = 55;
    localparam int unsigned NCOMP_W      = 16;
    localparam int unsigned NCOMP_BYTES  = NCOMP_W / 8;
    localparam int unsigned MIN_HLEN     = LEN_POS + 2;
    localparam int unsigned MIN_SIZE_POS = NCOMP_POS + NCOMP_BYTES;

    // Lookup record layout
    localparam int unsigned REC_LEN      = 9;
    localparam int unsigned REC_WORD_END = 4;
    localparam int unsigned OFS_W        = 32;
    localparam logic [7:0]  ID_PAYLOAD   = 8'd8;
    localparam logic [7:0]  ID_SIZES     = 8'd5;

    // Component sizes and frame scaling
    localparam int unsigned SIZE_W       = 22;
    localparam int unsigned FRAME_SHIFT  = 4;
    localparam int unsigned SUM_W        = SIZE_W + NCOMP_W;
    localparam int unsigned BYTES_W      = SUM_W + FRAME_SHIFT;

    typedef enum logic [2:0] {
        PH_LEN,
        PH_NREC,
        PH_TABLE,
        PH_SEEK,
        PH_SIZES,
        PH_DONE,
        PH_FAIL
    } phase_e;

    typedef struct packed {
        logic             pay_seen;
        logic             size_seen;
        logic [OFS_W-1:0] pay_ofs;
        logic [OFS_W-1:0] size_ofs;
    } walk_t;

    function automatic logic finished(input phase_e ph);
        return (ph == PH_DONE) || (ph == PH_FAIL);
    endfunction

endpackage

// File: rtl/imghdr_table_walker.sv
module imghdr_table_walker
    import imghdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] nrec,
    input  logic       step,
    input  logic [7:0] din,
    output walk_t      walk_nx,
    output logic       both_hit,
    output logic       exhausted
);

    localparam int unsigned POS_W = $clog2(REC_LEN);

    logic [POS_W-1:0] pos_q;
    logic [7:0]       left_q;
    logic [7:0]       id_q;
    logic [23:0]      lo_q;
    walk_t            st_q;
    logic [OFS_W-1:0] word;
    logic             at_word;

    always_comb begin
        word    = {din, lo_q};
        at_word = step && (pos_q == POS_W'(REC_WORD_END));
        walk_nx = st_q;
        if (at_word && id_q == ID_PAYLOAD) begin
            walk_nx.pay_seen = 1'b1;
            walk_nx.pay_ofs  = word;
        end
        if (at_word && id_q == ID_SIZES) begin
            walk_nx.size_seen = 1'b1;
            walk_nx.size_ofs  = word;
        end
        both_hit  = at_word && walk_nx.pay_seen && walk_nx.size_seen;
        exhausted = step && (pos_q == POS_W'(REC_LEN - 1)) && (left_q == 8'd1)
                    && !(st_q.pay_seen && st_q.size_seen);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            left_q <= '0;
            id_q   <= '0;
            lo_q   <= '0;
            st_q   <= '0;
        end else if (load) begin
            pos_q  <= '0;
            left_q <= nrec;
            st_q   <= '0;
        end else if (step) begin
            st_q <= walk_nx;
            if (pos_q == '0) begin
                id_q <= din;
            end else if (pos_q < POS_W'(REC_WORD_END)) begin
                lo_q <= {din, lo_q[23:8]};
            end
            if (pos_q == POS_W'(REC_LEN - 1)) begin
                pos_q  <= '0;
                left_q <= left_q - 8'd1;
            end else begin
                pos_q <= pos_q + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/imghdr_size_summer.sv
module imghdr_size_summer
    import imghdr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [7:0]         din,
    input  logic [NCOMP_W-1:0] ncomp,
    output logic [SUM_W-1:0]   sum,
    output logic               last_field
);

    // At most SIZE_W-1 bits wait in the buffer, so one byte completes at most one field.
    localparam int unsigned BUF_W  = SIZE_W + 7;
    localparam int unsigned FILL_W = $clog2(BUF_W + 1);

    logic [BUF_W-1:0]   bits_q;
    logic [BUF_W-1:0]   joined;
    logic [FILL_W-1:0]  fill_q;
    logic [FILL_W:0]    tot;
    logic               have;
    logic [NCOMP_W-1:0] got_q;
    logic [SUM_W-1:0]   sum_q;

    always_comb begin
        joined     = bits_q | (BUF_W'(din) << fill_q);
        tot        = {1'b0, fill_q} + (FILL_W + 1)'(8);
        have       = tot >= (FILL_W + 1)'(SIZE_W);
        last_field = step && have
                     && (({1'b0, got_q} + (NCOMP_W + 1)'(1)) == {1'b0, ncomp});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            fill_q <= '0;
            got_q  <= '0;
            sum_q  <= '0;
        end else if (step) begin
            if (have) begin
                sum_q  <= sum_q + SUM_W'(joined[SIZE_W-1:0]);
                bits_q <= joined >> SIZE_W;
                fill_q <= FILL_W'(tot - (FILL_W + 1)'(SIZE_W));
                got_q  <= got_q + NCOMP_W'(1);
            end else begin
                bits_q <= joined;
                fill_q <= FILL_W'(tot);
            end
        end
    end

    assign sum = sum_q;

endmodule

// File: rtl/imghdr_parser.sv
module imghdr_parser
    import imghdr_pkg::*;
#(
    parameter int unsigned IDX_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    output logic               in_ready,
    output logic               done,
    output logic               fmt_err,
    output logic [OFS_W-1:0]   pay_start,
    output logic [BYTES_W-1:0] pay_bytes
);

    phase_e             phase_q, ph_nx;
    logic [IDX_W-1:0]   idx_q;
    logic [7:0]         hlen_q;
    logic [NCOMP_W-1:0] ncomp_q;
    logic [OFS_W-1:0]   pay_start_q;
    logic [OFS_W-1:0]   size_pos_q;
    logic               accept;
    logic               walk_load, walk_step, sum_step;
    walk_t              walk_nx;
    logic               both_hit, exhausted, last_field, size_bad;
    logic [SUM_W-1:0]   sum;

    assign in_ready = !finished(phase_q);
    assign accept   = in_valid && in_ready;

    imghdr_table_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (walk_load),
        .nrec      (in_data),
        .step      (walk_step),
        .din       (in_data),
        .walk_nx   (walk_nx),
        .both_hit  (both_hit),
        .exhausted (exhausted)
    );

    imghdr_size_summer u_sum (
        .clk        (clk),
        .rst        (rst),
        .step       (sum_step),
        .din        (in_data),
        .ncomp      (ncomp_q),
        .sum        (sum),
        .last_field (last_field)
    );

    // The size array must start after the count bytes and after the byte that ends the walk.
    assign size_bad = (walk_nx.size_ofs < OFS_W'(MIN_SIZE_POS))
                      || (64'(walk_nx.size_ofs) <= 64'(idx_q));

    always_comb begin
        ph_nx     = phase_q;
        walk_load = 1'b0;
        walk_step = 1'b0;
        sum_step  = 1'b0;
        if (accept) begin
            case (phase_q)
                PH_LEN: begin
                    if (idx_q == IDX_W'(LEN_POS)) begin
                        ph_nx = (in_data < 8'(MIN_HLEN)) ? PH_FAIL : PH_NREC;
                    end
                end
                PH_NREC: begin
                    if (idx_q == IDX_W'(hlen_q) - IDX_W'(1)) begin
                        if (in_data == 8'd0) begin
                            ph_nx = PH_FAIL;
                        end else begin
                            walk_load = 1'b1;
                            ph_nx     = PH_TABLE;
                        end
                    end
                end
                PH_TABLE: begin
                    walk_step = 1'b1;
                    if (both_hit) begin
                        ph_nx = size_bad ? PH_FAIL : PH_SEEK;
                    end else if (exhausted) begin
                        ph_nx = PH_FAIL;
                    end
                end
                PH_SEEK: begin
                    if (64'(idx_q) == 64'(size_pos_q)) begin
                        if (ncomp_q == '0) begin
                            ph_nx = PH_DONE;
                        end else begin
                            sum_step = 1'b1;
                            ph_nx    = last_field ? PH_DONE : PH_SIZES;
                        end
                    end
                end
                PH_SIZES: begin
                    sum_step = 1'b1;
                    if (last_field) begin
                        ph_nx = PH_DONE;
                    end
                end
                default: ;
            endcase
            if (in_last && ph_nx != PH_DONE) begin
                ph_nx = PH_FAIL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_LEN;
            idx_q       <= '0;
            hlen_q      <= '0;
            ncomp_q     <= '0;
            pay_start_q <= '0;
            size_pos_q  <= '0;
        end else begin
            phase_q <= ph_nx;
            if (accept) begin
                idx_q <= idx_q + IDX_W'(1);
                for (int b = 0; b < int'(NCOMP_BYTES); b++) begin
                    if (idx_q == IDX_W'(NCOMP_POS + b)) begin
                        ncomp_q[8*b +: 8] <= in_data;
                    end
                end
                if (phase_q == PH_LEN && idx_q == IDX_W'(LEN_POS)) begin
                    hlen_q <= in_data;
                end
                if (phase_q == PH_TABLE && both_hit) begin
                    pay_start_q <= walk_nx.pay_ofs;
                    size_pos_q  <= walk_nx.size_ofs;
                end
            end
        end
    end

    assign done      = (phase_q == PH_DONE);
    assign fmt_err   = (phase_q == PH_FAIL);
    assign pay_start = pay_start_q;
    assign pay_bytes = {sum, FRAME_SHIFT'(0)};

endmodule

// File: rtl/imghdr_parser_chk.sv
module imghdr_parser_chk
    import imghdr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_last,
    input logic               in_ready,
    input logic               done,
    input logic               fmt_err,
    input logic [OFS_W-1:0]   pay_start,
    input logic [BYTES_W-1:0] pay_bytes
);

    // R9
    excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && fmt_err));

    // R9
    ready_chk: assert property (@(posedge clk) disable iff (rst)
        (done || fmt_err) |-> !in_ready);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(pay_bytes) && $stable(pay_start)));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fmt_err |=> fmt_err);

    // R8
    last_end_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> (done || fmt_err));

    // R11
    done_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(in_valid && in_ready));

    // R11
    err_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fmt_err) |-> $past(in_valid && in_ready));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!done && !fmt_err && in_ready && pay_bytes == '0 && pay_start == '0));

endmodule

bind imghdr_parser imghdr_parser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .done      (done),
    .fmt_err   (fmt_err),
    .pay_start (pay_start),
    .pay_bytes (pay_bytes)
);

// File: tb/imghdr_parser_bench.sv
`timescale 1ns/1ps
module imghdr_parser_bench;

    localparam int IMG_MAX = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_last = 1'b0;
    logic        in_ready, done, fmt_err;
    logic [31:0] pay_start;
    logic [41:0] pay_bytes;

    int checks = 0;
    int errors = 0;
    logic [7:0] img [IMG_MAX];
    int img_len;

    always #2.5 clk = ~clk;

    imghdr_parser #(.IDX_W(32)) u_imghdr_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .done(done), .fmt_err(fmt_err),
        .pay_start(pay_start), .pay_bytes(pay_bytes)
    );

    typedef struct packed {
        logic [7:0]  hlen;
        logic [7:0]  nrec;
        logic [7:0]  pay_rec;   // 255: absent
        logic [7:0]  size_rec;  // 255: absent
        logic        dup;       // record 0 carries an earlier payload id
        logic [15:0] size_pos;
        logic [15:0] ncomp;
        logic [15:0] seed;      // 0: all-ones sizes
        logic        stall;
        logic        bad;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{8'd28, 8'd3, 8'd0,   8'd1,   1'b0, 16'd80,  16'd3,  16'd1, 1'b0, 1'b0, 4'd6},
        '{8'd26, 8'd3, 8'd2,   8'd0,   1'b0, 16'd120, 16'd5,  16'd2, 1'b1, 1'b0, 4'd11},
        '{8'd30, 8'd2, 8'd0,   8'd255, 1'b0, 16'd90,  16'd2,  16'd3, 1'b0, 1'b1, 4'd4},
        '{8'd28, 8'd2, 8'd1,   8'd0,   1'b0, 16'd70,  16'd0,  16'd4, 1'b0, 1'b0, 4'd7},
        '{8'd28, 8'd2, 8'd0,   8'd1,   1'b0, 16'd50,  16'd2,  16'd1, 1'b0, 1'b1, 4'd5},
        '{8'd20, 8'd2, 8'd0,   8'd1,   1'b0, 16'd80,  16'd2,  16'd1, 1'b0, 1'b1, 4'd1},
        '{8'd28, 8'd0, 8'd255, 8'd255, 1'b0, 16'd80,  16'd2,  16'd1, 1'b0, 1'b1, 4'd2},
        '{8'd60, 8'd3, 8'd2,   8'd0,   1'b0, 16'd70,  16'd2,  16'd1, 1'b0, 1'b1, 4'd5},
        '{8'd28, 8'd3, 8'd1,   8'd2,   1'b1, 16'd100, 16'd4,  16'd5, 1'b0, 1'b0, 4'd3},
        '{8'd30, 8'd2, 8'd1,   8'd0,   1'b0, 16'd64,  16'd40, 16'd0, 1'b0, 1'b0, 4'd6},
        '{8'd28, 8'd2, 8'd0,   8'd1,   1'b0, 16'd57,  16'd1,  16'd9, 1'b1, 1'b0, 4'd6}
    };

    function automatic string rname(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; default: return "R11";
        endcase
    endfunction

    function automatic logic [21:0] size_val(input int seed, input int i);
        if (seed == 0) return '1;
        return 22'((seed * (i + 3) * 40503) ^ (i * 977));
    endfunction

    function automatic logic [31:0] pay_val(input int vi);
        return 32'h0A00_03C5 + 32'(vi << 12);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_rec(input int base, input logic [7:0] id, input logic [31:0] ofs);
        img[base] = id;
        for (int j = 0; j < 4; j++) img[base + 1 + j] = ofs[8*j +: 8];
    endtask

    task automatic build(input vec_t v, input int vi, output longint exp_bytes);
        int stop;
        bit both;
        longint total;
        logic [21:0] s;
        for (int k = 0; k < IMG_MAX; k++) img[k] = 8'(k * 7 + 3) ^ 8'h5A;
        both = (v.pay_rec != 8'd255) && (v.size_rec != 8'd255);
        stop = (v.pay_rec > v.size_rec) ? int'(v.pay_rec) : int'(v.size_rec);
        for (int r = 0; r < int'(v.nrec); r++) begin
            if (r == int'(v.pay_rec))       put_rec(v.hlen + 9*r, 8'd8, pay_val(vi));
            else if (r == int'(v.size_rec)) put_rec(v.hlen + 9*r, 8'd5, 32'(v.size_pos));
            else if (v.dup && r == 0)       put_rec(v.hlen + 9*r, 8'd8, 32'h0000_1E61);
            else if (both && r > stop)      put_rec(v.hlen + 9*r, 8'd5, 32'd3); // R3 decoy
            else                            put_rec(v.hlen + 9*r, 8'd3, 32'd3);
        end
        total = 0;
        for (int i = 0; i < int'(v.ncomp); i++) begin
            s = size_val(int'(v.seed), i);
            total += longint'(s);
            for (int b = 0; b < 22; b++) begin
                int p;
                p = int'(v.size_pos) * 8 + i * 22 + b;
                img[p / 8][p % 8] = s[b];
            end
        end
        img[24] = v.hlen;
        img[int'(v.hlen) - 1] = v.nrec;
        img[55] = v.ncomp[7:0];
        img[56] = v.ncomp[15:8];
        exp_bytes = total * 16;
        img_len = int'(v.size_pos) + ((v.ncomp == 0) ? 1 : (int'(v.ncomp) * 22 + 7) / 8);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        in_last = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Starts and ends at a negedge. pre/post: done just before and just after the final byte.
    task automatic feed(input int n, input bit stall, output int taken,
                        output bit pre, output bit post);
        taken = 0;
        pre = 1'b0;
        post = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (!in_ready) break;
            in_valid = 1'b1;
            in_data  = img[k];
            in_last  = (k == n - 1);
            if (k == n - 1) pre = done;
            @(posedge clk);
            taken++;
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (k == n - 1) post = done;
            if (stall) begin
                in_data = 8'hFF;
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int taken;
        bit pre, post;
        longint exp_bytes;
        logic [41:0] held;

        // R10: reset state
        do_reset();
        chk(in_ready == 1'b1 && done == 1'b0 && fmt_err == 1'b0, "R10",
            {in_ready, done, fmt_err}, 3'b100);
        chk(pay_bytes == '0 && pay_start == '0, "R10", pay_bytes, 0);

        // Descriptor table walk
        for (int vi = 0; vi < 11; vi++) begin
            vec_t v;
            string rq;
            v = VECS[vi];
            rq = rname(int'(v.req));
            do_reset();
            build(v, vi, exp_bytes);
            feed(img_len, v.stall, taken, pre, post);
            if (v.bad) begin
                chk(fmt_err == 1'b1 && done == 1'b0, rq, {done, fmt_err}, 2'b01);
            end else begin
                chk(pre == 1'b0 && post == 1'b1 && fmt_err == 1'b0, rq,
                    {pre, post, fmt_err}, 3'b010);
                chk(pay_bytes == 42'(exp_bytes), rq, pay_bytes, exp_bytes);
                if (v.ncomp != 0) begin
                    // R3: payload offset, including duplicate identifier and decoy records
                    chk(pay_start == pay_val(vi), "R3", pay_start, pay_val(vi));
                end
            end
        end

        // R8: stream ends four bytes early
        do_reset();
        build(VECS[0], 0, exp_bytes);
        feed(img_len - 4, 1'b0, taken, pre, post);
        chk(fmt_err == 1'b1 && done == 1'b0, "R8", {done, fmt_err}, 2'b01);

        // R9: bytes offered after completion are refused and change nothing
        do_reset();
        build(VECS[0], 0, exp_bytes);
        feed(img_len, 1'b0, taken, pre, post);
        held = pay_bytes;
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1;
            in_data  = 8'h00;
            in_last  = 1'b1;
            chk(in_ready == 1'b0, "R9", in_ready, 0);
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(done == 1'b1 && fmt_err == 1'b0 && pay_bytes == held, "R9",
            pay_bytes, held);
        chk(pay_start == pay_val(0), "R9", pay_start, pay_val(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule